// File: doc/BRIEF.md
# Tagged Register File with Consuming Move

This block is a 32-entry register file in which every entry is 129 bits: a tag bit that says whether the entry holds a capability, plus 128 payload bits. A capability uses all 128 payload bits. An integer uses the low 64 bits, and the upper 64 bits are held at zero. The file has two combinational read ports and one synchronous write port. Each read port returns the payload together with its tag.

A separate move operation copies one entry into another in a single clock. When the moved value is anything other than a non-linear capability, the move also overwrites the source with a null capability in the same clock. Two consequences follow:

- A linear capability can never be duplicated by moving it between registers.
- Integers are consumed in the same way, because only a non-linear capability is exempt from the clear.

Entry 0 is hardwired to zero and silently drops every write to it. Capabilities are identified by the tag and by the type field in payload bits [126:124]. The other capability fields are carried through untouched and are not interpreted.

Top module: `tagRegFile`

## Requirements
- R1: After reset every entry reads back payload zero with the tag clear (integer zero).
- R2: Reading entry 0 on either port always returns payload zero and a clear tag.
- R3: Writes that target entry 0 are dropped without error, whether they come from an ordinary write or from the destination of a move.
- R4: An ordinary write is visible on the read ports from the cycle after the clock edge that accepts it, and not before.
  - When the write's capability flag is 1, the entry stores all 128 data bits and sets the tag.
  - When the flag is 0, the entry stores the low 64 bits, stores zero in the upper 64 bits, and clears the tag.
- R5: A move whose source index equals its destination index changes nothing.
- R6: A move with different indices copies the source's tag and payload, as they were before the edge, into the destination.
- R7: After a move with different indices, the source is left unchanged only when its tag is 1 and its type field (payload bits [126:124]) equals 1, the non-linear code. In every other case the source becomes the null capability: tag 1, payload zero.
- R8: A move with destination 0 still clears the source by the rule of R7. Only the destination write is dropped.
- R9: If an ordinary write targets the same register as a move's source clear or a move's destination in the same cycle, the ordinary write's value is what that register holds afterwards.
- R10: The output wrTgtIsCap shows, combinationally, the tag currently held by the entry addressed by wrAddr. It reads 0 for entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdAddrA | input | 5 | Read port A index |
| rdDataA | output | 128 | Read port A payload |
| rdIsCapA | output | 1 | Read port A tag |
| rdAddrB | input | 5 | Read port B index |
| rdDataB | output | 128 | Read port B payload |
| rdIsCapB | output | 1 | Read port B tag |
| wrEn | input | 1 | Ordinary write strobe |
| wrAddr | input | 5 | Ordinary write index |
| wrData | input | 128 | Ordinary write payload |
| wrIsCap | input | 1 | 1 = capability write, 0 = integer write |
| wrTgtIsCap | output | 1 | Tag currently held at wrAddr |
| mvEn | input | 1 | Move strobe |
| mvSrc | input | 5 | Move source index |
| mvDst | input | 5 | Move destination index |

## Verification
The two read ports and wrTgtIsCap are combinational, so the bench checks them a little after it changes an address and with no edge in between. The effects of writes and moves are due one register stage after the accepting rising edge. The bench therefore applies each operation at a falling edge, updates its reference model at the following rising edge, and reads the file back only at the next falling edge, after the enables have dropped. Directed sequences cover the entry-0 cases, same-index moves, moves of non-linear, linear and integer values, and collisions between writes and moves. Random operations from a fixed seed are then checked in full against the reference model.

// File: rtl/tagRegFilePkg.sv
package tagRegFilePkg;
  localparam int REG_COUNT = 32;
  localparam int IDX_W = $clog2(REG_COUNT);
  localparam int CLEN = 128;
  localparam int XLEN = 64;
  localparam int TYPE_HI = 126;
  localparam int TYPE_LO = 124;
  localparam int TYPE_W = TYPE_HI - TYPE_LO + 1;
  localparam logic [TYPE_W-1:0] TYPE_NONLINEAR = TYPE_W'(1);

  typedef struct packed {
    logic            tag;
    logic [CLEN-1:0] bits;
  } entry_t;

  localparam entry_t NULL_CAP = '{tag: 1'b1, bits: '0};
  localparam entry_t INT_ZERO = '{tag: 1'b0, bits: '0};

  typedef struct packed {
    logic             wrWe;
    logic [IDX_W-1:0] wrIdx;
    logic             dstWe;
    logic [IDX_W-1:0] dstIdx;
    logic             srcClr;
    logic [IDX_W-1:0] srcIdx;
  } rfStrobe_t;
endpackage

// File: rtl/tagRegFileCtrl.sv
module tagRegFileCtrl
  import tagRegFilePkg::*;
(
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrAddr,
  input  logic              mvEn,
  input  logic [IDX_W-1:0]  mvSrc,
  input  logic [IDX_W-1:0]  mvDst,
  input  logic              srcTag,
  input  logic [TYPE_W-1:0] srcType,
  output rfStrobe_t         strobe
);
  logic mvActive;
  logic srcNonLinear;

  always_comb begin
    mvActive      = mvEn && (mvSrc != mvDst);
    srcNonLinear  = srcTag && (srcType == TYPE_NONLINEAR);
    strobe.wrWe   = wrEn && (wrAddr != '0);
    strobe.wrIdx  = wrAddr;
    strobe.dstWe  = mvActive && (mvDst != '0);
    strobe.dstIdx = mvDst;
    strobe.srcClr = mvActive && (mvSrc != '0) && !srcNonLinear;
    strobe.srcIdx = mvSrc;
  end
endmodule

// File: rtl/tagRegFileData.sv
module tagRegFileData
  import tagRegFilePkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  rfStrobe_t         strobe,
  input  logic [CLEN-1:0]   wrData,
  input  logic              wrIsCap,
  input  logic [IDX_W-1:0]  rdAddrA,
  input  logic [IDX_W-1:0]  rdAddrB,
  input  logic [IDX_W-1:0]  wrAddr,
  input  logic [IDX_W-1:0]  mvSrc,
  output entry_t            rdEntryA,
  output entry_t            rdEntryB,
  output logic              wrTgtTag,
  output logic              srcTag,
  output logic [TYPE_W-1:0] srcType
);
  entry_t mem [1:REG_COUNT-1];
  entry_t wrEntry;
  entry_t srcEntry;

  function automatic entry_t readAt(input logic [IDX_W-1:0] idx);
    entry_t e;
    e = INT_ZERO;
    for (int k = 1; k < REG_COUNT; k++)
      if (idx == IDX_W'(k)) e = mem[k];
    return e;
  endfunction

  always_comb begin
    wrEntry.tag  = wrIsCap;
    wrEntry.bits = wrIsCap ? wrData : {{(CLEN-XLEN){1'b0}}, wrData[XLEN-1:0]};
    srcEntry     = readAt(mvSrc);
    rdEntryA     = readAt(rdAddrA);
    rdEntryB     = readAt(rdAddrB);
    wrTgtTag     = readAt(wrAddr).tag;
    srcTag       = srcEntry.tag;
    srcType      = srcEntry.bits[TYPE_HI:TYPE_LO];
  end

  for (genvar gi = 1; gi < REG_COUNT; gi++) begin : g_entry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        mem[gi] <= INT_ZERO;
      else if (strobe.wrWe && strobe.wrIdx == IDX_W'(gi))
        mem[gi] <= wrEntry;
      else if (strobe.dstWe && strobe.dstIdx == IDX_W'(gi))
        mem[gi] <= srcEntry;
      else if (strobe.srcClr && strobe.srcIdx == IDX_W'(gi))
        mem[gi] <= NULL_CAP;
    end
  end

  // R4: an accepted write is held at its index after the edge
  p_write_lands_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrWe |=> mem[$past(strobe.wrIdx)] == $past(wrEntry));

  // R6: the destination receives the pre-edge source value
  p_move_copy_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.dstWe && !(strobe.wrWe && strobe.wrIdx == strobe.dstIdx))
    |=> mem[$past(strobe.dstIdx)] == $past(srcEntry));

  // R7: a consumed source becomes the null capability
  p_src_null_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.srcClr && !(strobe.wrWe && strobe.wrIdx == strobe.srcIdx))
    |=> mem[$past(strobe.srcIdx)] == NULL_CAP);

  // R9: an ordinary write overrides a colliding move destination
  p_write_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrWe && strobe.dstWe && strobe.wrIdx == strobe.dstIdx)
    |=> mem[$past(strobe.dstIdx)] == $past(wrEntry));
endmodule

// File: rtl/tagRegFile.sv
module tagRegFile
  import tagRegFilePkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] rdAddrA,
  output logic [CLEN-1:0]  rdDataA,
  output logic             rdIsCapA,
  input  logic [IDX_W-1:0] rdAddrB,
  output logic [CLEN-1:0]  rdDataB,
  output logic             rdIsCapB,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrAddr,
  input  logic [CLEN-1:0]  wrData,
  input  logic             wrIsCap,
  output logic             wrTgtIsCap,
  input  logic             mvEn,
  input  logic [IDX_W-1:0] mvSrc,
  input  logic [IDX_W-1:0] mvDst
);
  rfStrobe_t         strobe;
  entry_t            rdEntryA;
  entry_t            rdEntryB;
  logic              srcTag;
  logic [TYPE_W-1:0] srcType;

  tagRegFileCtrl i_ctrl (
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .mvEn    (mvEn),
    .mvSrc   (mvSrc),
    .mvDst   (mvDst),
    .srcTag  (srcTag),
    .srcType (srcType),
    .strobe  (strobe)
  );

  tagRegFileData i_data (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (wrData),
    .wrIsCap  (wrIsCap),
    .rdAddrA  (rdAddrA),
    .rdAddrB  (rdAddrB),
    .wrAddr   (wrAddr),
    .mvSrc    (mvSrc),
    .rdEntryA (rdEntryA),
    .rdEntryB (rdEntryB),
    .wrTgtTag (wrTgtIsCap),
    .srcTag   (srcTag),
    .srcType  (srcType)
  );

  assign rdDataA  = rdEntryA.bits;
  assign rdIsCapA = rdEntryA.tag;
  assign rdDataB  = rdEntryB.bits;
  assign rdIsCapB = rdEntryB.tag;
endmodule

// File: tb/test_tagRegFile.sv
module test_tagRegFile;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0] rdAddrA = '0, rdAddrB = '0, wrAddr = '0, mvSrc = '0, mvDst = '0;
  logic [127:0] rdDataA, rdDataB, wrData = '0;
  logic rdIsCapA, rdIsCapB, wrTgtIsCap;
  logic wrEn = 1'b0, wrIsCap = 1'b0, mvEn = 1'b0;

  int checks = 0;
  int errors = 0;

  logic         mTag  [32];
  logic [127:0] mData [32];

  always #10 clk = ~clk;

  tagRegFile i_tagRegFile (
    .clk(clk), .rstN(rstN),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdIsCapA(rdIsCapA),
    .rdAddrB(rdAddrB), .rdDataB(rdDataB), .rdIsCapB(rdIsCapB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .wrIsCap(wrIsCap),
    .wrTgtIsCap(wrTgtIsCap),
    .mvEn(mvEn), .mvSrc(mvSrc), .mvDst(mvDst)
  );

  function automatic logic [127:0] capOf(input logic [2:0] ty, input logic [63:0] lo);
    return {1'b1, ty, 3'b101, 57'h0AB_CDEF_0123_4567, lo};
  endfunction

  task automatic check(input string req, input logic [128:0] got, input logic [128:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic applyModel(input logic we, input logic [4:0] wa, input logic [127:0] wd,
                            input logic wc, input logic me, input logic [4:0] ms,
                            input logic [4:0] md);
    logic         sTag;
    logic [127:0] sData;
    sTag  = mTag[ms];
    sData = mData[ms];
    if (me && ms != md) begin
      if (md != 0) begin mTag[md] = sTag; mData[md] = sData; end
      if (ms != 0 && !(sTag && sData[126:124] == 3'd1)) begin
        mTag[ms] = 1'b1; mData[ms] = '0;
      end
    end
    if (we && wa != 0) begin
      mTag[wa]  = wc;
      mData[wa] = wc ? wd : {64'h0, wd[63:0]};
    end
  endtask

  task automatic op(input logic we, input logic [4:0] wa, input logic [127:0] wd,
                    input logic wc, input logic me, input logic [4:0] ms, input logic [4:0] md);
    @(negedge clk);
    wrEn = we; wrAddr = wa; wrData = wd; wrIsCap = wc;
    mvEn = me; mvSrc = ms; mvDst = md;
    @(posedge clk);
    applyModel(we, wa, wd, wc, me, ms, md);
    @(negedge clk);
    wrEn = 1'b0; mvEn = 1'b0;
  endtask

  task automatic readCheck(input string req, input logic [4:0] a, input logic [4:0] b);
    rdAddrA = a; rdAddrB = b; wrAddr = a;
    #2;
    check(req, {rdIsCapA, rdDataA}, {mTag[a], mData[a]});
    check(req, {rdIsCapB, rdDataB}, {mTag[b], mData[b]});
    check({req, " R10"}, {128'h0, wrTgtIsCap}, {128'h0, mTag[a]});
  endtask

  task automatic checkAll(input string req);
    for (int i = 0; i < 32; i += 2) readCheck(req, 5'(i), 5'(i + 1));
  endtask

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd12345));
    for (int i = 0; i < 32; i++) begin mTag[i] = 1'b0; mData[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    checkAll("R1 reset");

    // R3 + R2: write to entry 0 dropped, entry 0 reads zero
    op(1, 0, capOf(3'd0, 64'h55), 1, 0, 0, 0);
    readCheck("R2 R3 zero entry", 0, 0);

    // R4: capability and integer writes
    op(1, 3, capOf(3'd0, 64'h1111), 1, 0, 0, 0);
    op(1, 4, {64'hFFFF_FFFF_FFFF_FFFF, 64'h2222}, 0, 0, 0, 0);
    op(1, 5, capOf(3'd1, 64'h3333), 1, 0, 0, 0);
    readCheck("R4 writes", 3, 4);
    readCheck("R4 writes", 5, 6);

    // R4: not visible before the edge
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 7; wrData = capOf(3'd2, 64'h7); wrIsCap = 1'b1;
    rdAddrA = 7; #2;
    check("R4 before edge", {rdIsCapA, rdDataA}, 129'h0);
    @(posedge clk); applyModel(1, 7, capOf(3'd2, 64'h7), 1, 0, 0, 0);
    @(negedge clk); wrEn = 1'b0;
    readCheck("R4 after edge", 7, 7);

    // R5: same-index move
    op(0, 0, '0, 0, 1, 3, 3);
    readCheck("R5 same index", 3, 3);

    // R6 R7: non-linear kept, linear consumed, integer consumed
    op(0, 0, '0, 0, 1, 5, 8);
    readCheck("R6 R7 nonlinear", 5, 8);
    op(0, 0, '0, 0, 1, 3, 9);
    readCheck("R6 R7 linear", 3, 9);
    op(0, 0, '0, 0, 1, 4, 10);
    readCheck("R6 R7 integer", 4, 10);

    // R8: move to entry 0 still clears a linear source
    op(0, 0, '0, 0, 1, 9, 0);
    readCheck("R8 dst zero", 9, 0);
    // R8: move to entry 0 of a non-linear source keeps it
    op(0, 0, '0, 0, 1, 8, 0);
    readCheck("R8 dst zero nonlinear", 8, 0);

    // R9: write collides with source clear, then with destination
    op(1, 7, {64'h0, 64'hABCD}, 0, 1, 7, 11);
    readCheck("R9 write vs clear", 7, 11);
    op(1, 12, capOf(3'd3, 64'h99), 1, 1, 10, 12);
    readCheck("R9 write vs dst", 12, 10);

    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [127:0] d;
      logic [4:0] a1, a2, a3;
      d  = {$urandom, $urandom, $urandom, $urandom};
      d[126:124] = 3'($urandom_range(0, 2));
      a1 = 5'($urandom); a2 = 5'($urandom); a3 = 5'($urandom);
      if ($urandom_range(0, 7) == 0) a3 = a2;
      op($urandom_range(0, 1) == 1, a1, d, $urandom_range(0, 1) == 1,
         $urandom_range(0, 2) != 0, a2, a3);
      readCheck("R6 R7 R9 random", 5'($urandom), 5'($urandom));
      if (n % 100 == 99) checkAll("R4 R6 R7 random sweep");
    end
    checkAll("R2 R3 final");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule